// File: doc/BRIEF.md
# Seven-Register Datapath Driven by a Control Word

This block is the execution core of a small processor: seven general registers, two source selectors that place operands on an A bus and a B bus, an arithmetic-logic unit, and a destination decoder that writes the unit's result back into one register. A controller outside the block supplies one 14-bit control word per clock cycle. That word names the two sources, the destination and the operation, so each cycle carries out one register-transfer step, for example "register 1 gets register 2 minus register 3".

Either source selector can pick an external data input instead of a register. The destination selector can suppress the write altogether. The result output always shows what the unit computes from the current control word and the current register contents. This lets the block pass input data straight through, or show a register's value, without changing its state. The data width is a parameter, 8 bits by default. All arithmetic wraps modulo 2^DW.

Top module: `regbank_datapath`

## Requirements
- R1: The control word bits are laid out with the A-source select in [13:11], the B-source select in [10:8], the destination select in [7:5] and the operation code in [4:0].
- R2: A source select of 0 places `data_in` on that bus, and a select of k from 1 to 7 places register Rk on it. This holds for the A side and the B side alike.
- R3: A destination select of k from 1 to 7 loads `result_out` into Rk on the rising clock edge and leaves the other six registers unchanged. A destination select of 0 loads no register.
- R4: Operation codes: 00000 gives A, 00001 gives A+1, 00010 gives A+B, 00101 gives A-B, 00110 gives A-1, 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, and 01110 gives NOT A. All results wrap modulo 2^DW.
- R5: Code 10000 shifts A right by one place and code 11000 shifts A left by one place. Both shifts are logical, and the vacated bit is 0.
- R6: Any other operation code gives a result of 0, and the write-back to the selected destination still takes place.
- R7: An active-low reset, `rst_n`, clears all seven registers to zero.
- R8: `result_out` follows the control word and the registers without delay. When a register is both read and written in the same cycle, the read sees the value held before the edge.
- R9: The all-zero control word shows `data_in` on `result_out` and writes no register. The word 010 011 001 00101 performs R1 <- R2 - R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears all registers |
| data_in | input | DW | External operand, selected by source code 0 |
| ctrl_word | input | 14 | Source, destination and operation selects for this cycle |
| result_out | output | DW | Result of the operation on the two selected buses |

## Verification
The hardest case to produce is a write that lands on the same register being read in that cycle. The output must show the old value before the edge and the new value after it, and the write must not disturb any other register. The bench holds an increment with the same register as source and destination across one edge, and samples the output on both sides of that edge. It then reads all seven registers back with transfer operations to confirm the rest of the file is untouched. The unlisted-code write-back and the no-write control word are confirmed the same way, by reading every register back.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int SEL_W = 3;
  localparam int OP_W  = 5;
  localparam int CW_W  = 3 * SEL_W + OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 5'b00000,
    OP_INC  = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DEC  = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_NOT  = 5'b01110,
    OP_SHR  = 5'b10000,
    OP_SHL  = 5'b11000
  } alu_op_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel_a;
    logic [SEL_W-1:0] sel_b;
    logic [SEL_W-1:0] sel_d;
    logic [OP_W-1:0]  op;
  } ctrl_t;

  function automatic logic op_is_known(input logic [OP_W-1:0] op);
    case (op)
      OP_PASS, OP_INC, OP_ADD, OP_SUB, OP_DEC, OP_AND,
      OP_OR, OP_XOR, OP_NOT, OP_SHR, OP_SHL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rbd_src_mux.sv
module rbd_src_mux #(
  parameter int DW   = 8,
  parameter int SW   = 3,
  parameter int NREG = 7
) (
  input  logic [SW-1:0]      sel,
  input  logic [DW-1:0]      ext_in,
  input  logic [NREG*DW-1:0] reg_flat,
  output logic [DW-1:0]      bus_out
);
  always_comb begin
    bus_out = ext_in;
    for (int k = 1; k <= NREG; k++) begin
      if (sel == SW'(k)) bus_out = reg_flat[(k-1)*DW +: DW];
    end
  end
endmodule

// File: rtl/rbd_dest_decode.sv
module rbd_dest_decode #(
  parameter int SW   = 3,
  parameter int NREG = 7
) (
  input  logic [SW-1:0]   sel,
  output logic [NREG-1:0] load
);
  for (genvar k = 0; k < NREG; k++) begin : g_line
    assign load[k] = (sel == SW'(k + 1));
  end
endmodule

// File: rtl/rbd_alu.sv
module rbd_alu
  import rbd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [OP_W-1:0] op,
  output logic [DW-1:0]   y
);
  function automatic logic [DW-1:0] alu_eval(input logic [DW-1:0] x,
                                             input logic [DW-1:0] z,
                                             input logic [OP_W-1:0] code);
    case (code)
      OP_PASS: return x;
      OP_INC:  return x + DW'(1);
      OP_ADD:  return x + z;
      OP_SUB:  return x - z;
      OP_DEC:  return x - DW'(1);
      OP_AND:  return x & z;
      OP_OR:   return x | z;
      OP_XOR:  return x ^ z;
      OP_NOT:  return ~x;
      OP_SHR:  return x >> 1;
      OP_SHL:  return x << 1;
      default: return '0;
    endcase
  endfunction

  assign y = alu_eval(a, b, op);
endmodule

// File: rtl/rbd_regfile.sv
module rbd_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREG-1:0]    load,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] reg_flat
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (load[k]) q <= wdata;
    end
    assign reg_flat[k*DW +: DW] = q;
  end
endmodule

// File: rtl/regbank_datapath.sv
module regbank_datapath
  import rbd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   data_in,
  input  logic [CW_W-1:0] ctrl_word,
  output logic [DW-1:0]   result_out
);
  localparam int NREG = (1 << SEL_W) - 1;

  ctrl_t               cw;
  logic [DW-1:0]       bus_a;
  logic [DW-1:0]       bus_b;
  logic [NREG-1:0]     load_lines;
  logic [NREG*DW-1:0]  reg_flat;

  assign cw = ctrl_t'(ctrl_word);

  rbd_src_mux #(.DW(DW), .SW(SEL_W), .NREG(NREG)) i_mux_a (
    .sel(cw.sel_a), .ext_in(data_in), .reg_flat(reg_flat), .bus_out(bus_a));

  rbd_src_mux #(.DW(DW), .SW(SEL_W), .NREG(NREG)) i_mux_b (
    .sel(cw.sel_b), .ext_in(data_in), .reg_flat(reg_flat), .bus_out(bus_b));

  rbd_alu #(.DW(DW)) i_alu (
    .a(bus_a), .b(bus_b), .op(cw.op), .y(result_out));

  rbd_dest_decode #(.SW(SEL_W), .NREG(NREG)) i_dec (
    .sel(cw.sel_d), .load(load_lines));

  rbd_regfile #(.DW(DW), .NREG(NREG)) i_rf (
    .clk(clk), .rst_n(rst_n), .load(load_lines), .wdata(result_out),
    .reg_flat(reg_flat));
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker
  import rbd_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [DW-1:0]      data_in,
  input logic [CW_W-1:0]    ctrl_word,
  input logic [DW-1:0]      result_out,
  input logic [NREG-1:0]    load_lines,
  input logic [NREG*DW-1:0] reg_flat
);
  assert_single_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_lines))
    else $error("R3: more than one load line active");

  assert_no_load_on_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[7:5] == '0) |=> $stable(reg_flat))
    else $error("R3: register changed with destination 0");

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_lines[k] |=> reg_flat[k*DW +: DW] == $past(result_out))
      else $error("R3: write to register %0d lost", k + 1);

    assert_others_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !load_lines[k] |=> $stable(reg_flat[k*DW +: DW]))
      else $error("R3: register %0d changed without load", k + 1);
  end

  assert_unlisted_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !op_is_known(ctrl_word[OP_W-1:0]) |-> result_out == '0)
    else $error("R6: unlisted code gave nonzero result");

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> reg_flat == '0)
    else $error("R7: registers not zero after reset");

  assert_input_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word == '0) |-> result_out == data_in)
    else $error("R9: zero word did not pass input");
endmodule

bind regbank_datapath rbd_checker #(.DW(DW), .NREG(NREG)) i_rbd_checker (
  .clk(clk), .rst_n(rst_n), .data_in(data_in), .ctrl_word(ctrl_word),
  .result_out(result_out), .load_lines(load_lines), .reg_flat(reg_flat));

// File: tb/test_regbank_datapath.sv
module test_regbank_datapath;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic [13:0]   ctrl_word = '0;
  logic [DW-1:0] result_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regbank_datapath #(.DW(DW)) i_regbank_datapath (
    .clk(clk), .rst_n(rst_n), .data_in(data_in),
    .ctrl_word(ctrl_word), .result_out(result_out));

  // Field order per R1: {A[13:11], B[10:8], D[7:5], OP[4:0]}
  localparam logic [4:0] C_PASS = 5'b00000, C_INC = 5'b00001, C_ADD = 5'b00010,
    C_SUB = 5'b00101, C_DEC = 5'b00110, C_AND = 5'b01000, C_OR = 5'b01010,
    C_XOR = 5'b01100, C_NOT = 5'b01110, C_SHR = 5'b10000, C_SHL = 5'b11000;

  // entry = {ctrl_word[13:0], data_in[7:0], expected result[7:0]}
  localparam logic [29:0] VEC [NV] = '{
    {3'd0, 3'd0, 3'd1, C_PASS, 8'h05, 8'h05},
    {3'd0, 3'd0, 3'd2, C_PASS, 8'h0C, 8'h0C},
    {3'd0, 3'd0, 3'd3, C_PASS, 8'h03, 8'h03},
    {3'd2, 3'd3, 3'd1, C_SUB,  8'h00, 8'h09},
    {3'd2, 3'd3, 3'd4, C_ADD,  8'h00, 8'h0F},
    {3'd4, 3'd2, 3'd5, C_AND,  8'h00, 8'h0C},
    {3'd1, 3'd3, 3'd6, C_OR,   8'h00, 8'h0B},
    {3'd6, 3'd2, 3'd7, C_XOR,  8'h00, 8'h07},
    {3'd1, 3'd0, 3'd1, C_INC,  8'h00, 8'h0A},
    {3'd3, 3'd0, 3'd3, C_DEC,  8'h00, 8'h02},
    {3'd2, 3'd0, 3'd2, C_NOT,  8'h00, 8'hF3},
    {3'd2, 3'd0, 3'd4, C_SHR,  8'h00, 8'h79},
    {3'd2, 3'd0, 3'd5, C_SHL,  8'h00, 8'hE6},
    {3'd1, 3'd0, 3'd0, C_PASS, 8'h00, 8'h0A},
    {3'd0, 3'd0, 3'd0, C_PASS, 8'h5A, 8'h5A},
    {3'd0, 3'd0, 3'd0, C_ADD,  8'h40, 8'h80}
  };

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [13:0] cw, input logic [DW-1:0] din);
    @(negedge clk);
    ctrl_word = cw;
    data_in   = din;
    #1;
  endtask

  task automatic read_all(input string tag, input logic [8*7-1:0] exp_flat);
    for (int k = 1; k <= 7; k++) begin
      drive({3'(k), 3'd0, 3'd0, C_PASS}, 8'h00);
      check($sformatf("%s readback R%0d", tag, k), result_out,
            exp_flat[(7-k)*8 +: 8]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: all registers zero after reset
    read_all("R7 initial", {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});

    // R1 R2 R4 R5 R9: table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][29:16], VEC[i][15:8]);
      check($sformatf("R1 R2 R4 R5 table vec %0d", i), result_out, VEC[i][7:0]);
    end
    // R3: each write landed only where directed
    read_all("R3 after table", {8'h0A, 8'hF3, 8'h02, 8'h79, 8'hE6, 8'h0B, 8'h07});

    // R6: unlisted code gives zero and still writes R6
    drive({3'd1, 3'd2, 3'd6, 5'b00011}, 8'hFF);
    check("R6 unlisted result", result_out, 8'h00);
    drive({3'd6, 3'd0, 3'd0, C_PASS}, 8'h00);
    check("R6 write-back of zero", result_out, 8'h00);

    // R4 wraparound, no write
    drive({3'd3, 3'd1, 3'd0, C_SUB}, 8'h00);
    check("R4 sub wrap", result_out, 8'hF8);
    drive({3'd0, 3'd0, 3'd0, C_INC}, 8'hFF);
    check("R4 inc wrap", result_out, 8'h00);
    drive({3'd0, 3'd0, 3'd0, C_DEC}, 8'h00);
    check("R4 dec wrap", result_out, 8'hFF);
    // R5: zero fill on both shifts
    drive({3'd0, 3'd0, 3'd0, C_SHR}, 8'h81);
    check("R5 shr zero fill", result_out, 8'h40);
    drive({3'd0, 3'd0, 3'd0, C_SHL}, 8'h81);
    check("R5 shl zero fill", result_out, 8'h02);
    // R2: B side from a register, A side from input
    drive({3'd0, 3'd4, 3'd0, C_ADD}, 8'h01);
    check("R2 B-side register", result_out, 8'h7A);

    // R8: same-register read and write across one edge
    drive({3'd7, 3'd0, 3'd7, C_INC}, 8'h00);
    check("R8 before edge", result_out, 8'h08);
    @(posedge clk);
    #1;
    check("R8 after edge", result_out, 8'h09);

    // R9: zero word over a clock edge, then R1 <- R2 - R3 word
    drive(14'b000_000_000_00000, 8'h77);
    check("R9 zero word pass", result_out, 8'h77);
    read_all("R9 no write", {8'h0A, 8'hF3, 8'h02, 8'h79, 8'hE6, 8'h00, 8'h08});
    drive(14'b010_011_001_00101, 8'h00);
    check("R9 sub word", result_out, 8'hF1);
    drive({3'd1, 3'd0, 3'd0, C_PASS}, 8'h00);
    check("R9 sub word landed in R1", result_out, 8'hF1);

    // R7: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_all("R7 mid-run", {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});

    finish_run();
  end
endmodule